// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Port

A full-duplex asynchronous serial transceiver for one line pair. The transmit path turns a host-written character into a start bit, 7, 8 or 9 data bits (least significant first), an optional parity bit and a single stop bit. The receive path oversamples the line 16 times per bit, validates the start bit at mid-bit and checks parity and the stop bit. It holds one received character for the host. Both paths share a programmable tick generator that belongs to this port alone.

The host sees four things: a control word (tick divisor, character length, parity mode, address-wake enable), a transmit data write strobe, a receive data register with a read strobe, and a status word whose read clears the error flags. Two separate interrupt requests flag "transmitter can take a character" and "character waiting". A clear-to-send input holds back the start of each frame. A request-to-send output tells the far end to pause while a character is unread. In 9-bit mode the ninth bit can serve as an address flag, so a node on a shared bus can sleep through data frames until an address frame arrives.

Top module: `mdrop_uart`

## Requirements
- R1: After reset `txd` is 1, `irq_tx` is 1, `irq_rx` is 0, `rts_n` is 0 and `status` is 5'b00001; the control word resets to divisor 0, length code 1, parity code 0 and wake off.
- R2: The control word holds the divisor in bits [DIV_W-1:0]. Every transmitted bit lasts 16*(divisor+1) clock cycles.
- R3: A frame is a low start bit, then data bits LSB first, then an optional parity bit, then exactly one high stop bit. The data length is set by the length code in control bits [DIV_W+1:DIV_W]: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits. A received character appears right-aligned on `rx_rdata` with its unused upper bits at 0.
- R4: The parity code in control bits [DIV_W+3:DIV_W+2] selects the mode: 0 means none, 1 means even, 2 means odd. A received parity bit that does not match the data sets the parity error flag, `status[2]`.
- R5: A low line at the mid-point of the stop bit sets the framing error flag, `status[3]`. The character is still delivered.
- R6: If a character completes while the previous one is unread, the overrun flag `status[4]` is set. The new character is dropped and the held one is kept.
- R7: A `stat_rd` pulse clears `status[4:2]` on the next edge and leaves `status[1:0]` unchanged, unless a new error is set in the same cycle.
- R8: A falling edge on `rxd` starts a frame only if the line is still low 8 ticks later, at mid-start-bit. A shorter low pulse produces no character.
- R9: With address-wake (control bit DIV_W+4) set and a 9-bit length, a frame whose ninth bit is 0 is discarded and does not raise `irq_rx`. A frame whose ninth bit is 1 is delivered.
- R10: While `cts_n` is high, no new frame starts. A written character waits with `irq_tx` low and is sent once `cts_n` goes low.
- R11: `irq_tx` (also `status[0]`) is high when a character can be written. `irq_rx` (also `status[1]`) and `rts_n` are high while a received character is unread. A `rx_rd` pulse empties the receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | DIV_W+5 | Control word: wake, parity, length, divisor |
| tx_wr | input | 1 | Write strobe for a transmit character |
| tx_wdata | input | 9 | Transmit character, right-aligned |
| rx_rd | input | 1 | Read strobe that empties the receive register |
| rx_rdata | output | 9 | Received character |
| stat_rd | input | 1 | Status read strobe; clears the error flags |
| status | output | 5 | {overrun, framing, parity, rx full, tx ready} |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| irq_tx | output | 1 | Transmit-ready interrupt request |
| irq_rx | output | 1 | Receive-ready interrupt request |

## Verification
The bench builds the port with DIV_W = 8, so the divisor can be set freely at run time. The bench uses divisor 0, the fastest legal rate of 16 clocks per bit, for most traffic, which keeps every frame short. It uses divisor 2 to time a 48-cycle start bit. It loops `txd` back to `rxd` for the three lengths and parity modes. It drives hand-built frames for bad parity, a low stop bit and a short start glitch. The 9-bit length brings the address-wake filter within reach.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

  localparam int FRAME_W = 12;  // start + 9 data + parity + stop
  localparam int RBUF_W  = 11;  // data + parity + stop after the start bit

  typedef enum logic [1:0] {LEN_7 = 2'd0, LEN_8 = 2'd1, LEN_9 = 2'd2, LEN_RSV = 2'd3} len_e;
  typedef enum logic [1:0] {PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_RSV = 2'd3} par_e;

  function automatic logic [3:0] data_bits(logic [1:0] len);
    case (len)
      LEN_7:   data_bits = 4'd7;
      LEN_9:   data_bits = 4'd9;
      default: data_bits = 4'd8;
    endcase
  endfunction

  function automatic logic par_on(logic [1:0] par);
    par_on = (par == PAR_EVEN) || (par == PAR_ODD);
  endfunction

  function automatic logic [8:0] mask_data(logic [8:0] d, logic [3:0] n);
    logic [8:0] m;
    for (int i = 0; i < 9; i++) m[i] = (i < int'(n)) ? d[i] : 1'b0;
    mask_data = m;
  endfunction

  // parity bit that completes the selected sense over the masked data
  function automatic logic par_calc(logic [8:0] d, logic [3:0] n, logic [1:0] par);
    logic ones;
    ones = ^mask_data(d, n);
    par_calc = (par == PAR_ODD) ? ~ones : ones;
  endfunction

endpackage

// File: rtl/mdrop_baud.sv
module mdrop_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdrop_tx.sv
module mdrop_tx
  import mdrop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] len,
  input  logic [1:0] par,
  input  logic       cts_n,
  input  logic       wr,
  input  logic [8:0] wdata,
  output logic       txd,
  output logic       ready,
  output logic       active
);
  logic               hold_q, hold_d;
  logic               act_q, act_d;
  logic [FRAME_W-1:0] sh_q, sh_d, frame;
  logic [3:0]         left_q, left_d;
  logic [3:0]         sub_q, sub_d;
  logic [3:0]         n;
  logic               p;

  assign n = data_bits(len);
  assign p = par_on(par);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < int'(n)) frame[1+i] = wdata[i];
    if (p) frame[4'd1 + n] = par_calc(wdata, n, par);
  end

  always_comb begin
    hold_d = hold_q;
    act_d  = act_q;
    sh_d   = sh_q;
    left_d = left_q;
    sub_d  = sub_q;
    if (wr && !hold_q && !act_q) begin
      hold_d = 1'b1;
      sh_d   = frame;
      left_d = 4'd2 + n + {3'b000, p};
    end else if (hold_q && !act_q && !cts_n && tick) begin
      hold_d = 1'b0;
      act_d  = 1'b1;
      sub_d  = '0;
    end else if (act_q && tick) begin
      if (sub_q == 4'd15) begin
        sub_d  = '0;
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        left_d = left_q - 1'b1;
        if (left_q == 4'd1) act_d = 1'b0;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      act_q  <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
    end else begin
      hold_q <= hold_d;
      act_q  <= act_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      sub_q  <= sub_d;
    end
  end

  assign txd    = act_q ? sh_q[0] : 1'b1;
  assign ready  = !hold_q && !act_q;
  assign active = act_q;
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] len,
  input  logic [1:0] par,
  input  logic       wake,
  input  logic       rd,
  input  logic       stat_clr,
  output logic [8:0] rdata,
  output logic       full,
  output logic       pe,
  output logic       fe,
  output logic       oe,
  output logic       done,
  output logic       err_set
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

  rx_st_e            st_q, st_d;
  logic              s1_q, s2_q, prev_q, prev_d;
  logic [3:0]        sub_q, sub_d, idx_q, idx_d;
  logic [RBUF_W-1:0] rb_q, rb_d;
  logic [8:0]        dat_q, dat_d, dat_c;
  logic              full_q, full_d, pe_q, pe_d, fe_q, fe_d, oe_q, oe_d;
  logic [3:0]        n, last;
  logic              p, perr, stop_ok, accept, full_eff;

  assign n    = data_bits(len);
  assign p    = par_on(par);
  assign last = n + {3'b000, p};

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    idx_d  = idx_q;
    rb_d   = rb_q;
    prev_d = tick ? s2_q : prev_q;
    done   = 1'b0;
    case (st_q)
      RX_IDLE:
        if (tick && prev_q && !s2_q) begin
          st_d  = RX_START;
          sub_d = '0;
        end
      RX_START:
        if (tick) begin
          if (sub_q == 4'd7) begin
            st_d  = s2_q ? RX_IDLE : RX_BITS;
            sub_d = '0;
            idx_d = '0;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      default:
        if (tick) begin
          if (sub_q == 4'd15) begin
            sub_d      = '0;
            rb_d[idx_q] = s2_q;
            if (idx_q == last) begin
              done = 1'b1;
              st_d = RX_IDLE;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
    endcase
  end

  always_comb begin
    dat_c    = mask_data(rb_d[8:0], n);
    perr     = p && (rb_d[n] != par_calc(dat_c, n, par));
    stop_ok  = rb_d[last];
    accept   = !(wake && (len == LEN_9) && !dat_c[8]);
    full_eff = full_q && !rd;
    dat_d    = dat_q;
    full_d   = full_eff;
    pe_d     = pe_q && !stat_clr;
    fe_d     = fe_q && !stat_clr;
    oe_d     = oe_q && !stat_clr;
    err_set  = 1'b0;
    if (done && accept) begin
      if (full_eff) begin
        oe_d    = 1'b1;
        err_set = 1'b1;
      end else begin
        dat_d   = dat_c;
        full_d  = 1'b1;
        if (perr)     pe_d = 1'b1;
        if (!stop_ok) fe_d = 1'b1;
        err_set = perr || !stop_ok;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      idx_q  <= '0;
      rb_q   <= '0;
      dat_q  <= '0;
      full_q <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      prev_q <= prev_d;
      st_q   <= st_d;
      sub_q  <= sub_d;
      idx_q  <= idx_d;
      rb_q   <= rb_d;
      dat_q  <= dat_d;
      full_q <= full_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      oe_q   <= oe_d;
    end
  end

  assign rdata = dat_q;
  assign full  = full_q;
  assign pe    = pe_q;
  assign fe    = fe_q;
  assign oe    = oe_q;
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
  import mdrop_pkg::*;
#(
  parameter int DIV_W = 16,
  localparam int CTL_W = DIV_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             tx_wr,
  input  logic [8:0]       tx_wdata,
  input  logic             rx_rd,
  output logic [8:0]       rx_rdata,
  input  logic             stat_rd,
  output logic [4:0]       status,
  input  logic             rxd,
  output logic             txd,
  input  logic             cts_n,
  output logic             rts_n,
  output logic             irq_tx,
  output logic             irq_rx
);
  localparam logic [CTL_W-1:0] CTL_RST = CTL_W'(1) << DIV_W;  // 8-bit, no parity

  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [DIV_W-1:0] div;
  logic [1:0]       len, par;
  logic             wake, tick;
  logic             tx_ready, tx_act;
  logic             rx_full, rx_pe, rx_fe, rx_oe, rx_done, rx_err_set;

  assign ctl_d = ctl_wr ? ctl_wdata : ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_d;
  end

  assign div  = ctl_q[DIV_W-1:0];
  assign len  = ctl_q[DIV_W+1:DIV_W];
  assign par  = ctl_q[DIV_W+3:DIV_W+2];
  assign wake = ctl_q[DIV_W+4];

  mdrop_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
  );

  mdrop_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .len(len), .par(par),
    .cts_n(cts_n), .wr(tx_wr), .wdata(tx_wdata),
    .txd(txd), .ready(tx_ready), .active(tx_act)
  );

  mdrop_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .len(len), .par(par),
    .wake(wake), .rd(rx_rd), .stat_clr(stat_rd), .rdata(rx_rdata),
    .full(rx_full), .pe(rx_pe), .fe(rx_fe), .oe(rx_oe),
    .done(rx_done), .err_set(rx_err_set)
  );

  assign status = {rx_oe, rx_fe, rx_pe, rx_full, tx_ready};
  assign irq_tx = tx_ready;
  assign irq_rx = rx_full;
  assign rts_n  = rx_full;
endmodule

// File: rtl/mdrop_uart_chk.sv
module mdrop_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       cts_n,
  input logic       irq_tx,
  input logic       irq_rx,
  input logic       rts_n,
  input logic       stat_rd,
  input logic [4:0] status,
  input logic       tx_act,
  input logic       rx_done,
  input logic       rx_err_set,
  input logic       tick,
  input logic       div_nz
);
  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_tx |-> txd);

  // R10
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_act && cts_n) |=> !tx_act);

  // R11
  rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_rx |-> rts_n);

  // R9
  rx_ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> $past(rx_done));

  // R6
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> irq_rx);

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_err_set) |=> (status[4:2] == 3'b000));

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_nz) |=> !tick);
endmodule

bind mdrop_uart mdrop_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .cts_n(cts_n), .irq_tx(irq_tx),
  .irq_rx(irq_rx), .rts_n(rts_n), .stat_rd(stat_rd), .status(status),
  .tx_act(tx_act), .rx_done(rx_done), .rx_err_set(rx_err_set),
  .tick(tick), .div_nz(|div)
);

// File: tb/sim_mdrop_uart.sv
module sim_mdrop_uart;
  localparam int DIV_W = 8;
  localparam int CTL_W = DIV_W + 5;

  typedef struct {
    logic [8:0] data;
    logic [2:0] errs;  // {oe, fe, pe}
    string      tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctl_wr = 1'b0;
  logic [CTL_W-1:0] ctl_wdata = '0;
  logic             tx_wr = 1'b0;
  logic [8:0]       tx_wdata = '0;
  logic             rx_rd = 1'b0;
  logic [8:0]       rx_rdata;
  logic             stat_rd = 1'b0;
  logic [4:0]       status;
  logic             txd, rts_n, irq_tx, irq_rx;
  logic             cts_n = 1'b0;
  logic             loop_sel = 1'b1;
  logic             rxd_drv = 1'b1;
  logic             mon_en = 1'b1;
  logic             rxd_w;
  int               nchk = 0;
  int               nfail = 0;
  int               cur_div = 0;
  item_t            exp_q[$];

  assign rxd_w = loop_sel ? txd : rxd_drv;

  always #4 clk = ~clk;

  mdrop_uart #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .stat_rd(stat_rd), .status(status), .rxd(rxd_w), .txd(txd),
    .cts_n(cts_n), .rts_n(rts_n), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic set_ctl(int div, int len, int par, bit wake);
    @(negedge clk);
    ctl_wdata = {wake, 2'(par), 2'(len), DIV_W'(div)};
    ctl_wr = 1'b1;
    cur_div = div;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic push(logic [8:0] d, logic [2:0] e, string tag);
    item_t it;
    it.data = d; it.errs = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic send_tx(logic [8:0] d);
    @(negedge clk);
    while (!irq_tx) @(negedge clk);
    tx_wdata = d;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic raw(logic [11:0] bits, int nb);
    loop_sel = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rxd_drv = bits[i];
      repeat (16 * (cur_div + 1) - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd_drv = 1'b1;
  endtask

  // scoreboard monitor
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (mon_en && irq_rx) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected char", int'(rx_rdata), 0);
        end else begin
          e = exp_q.pop_front();
          check(rx_rdata == e.data, {e.tag, " data"}, int'(rx_rdata), int'(e.data));
          check(status[4:2] == e.errs, {e.tag, " errs"}, int'(status[4:2]), int'(e.errs));
        end
        rx_rd = 1'b1;
        stat_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        stat_rd = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd", int'(txd), 1);
    check(irq_tx == 1'b1, "R1 irq_tx", int'(irq_tx), 1);
    check(irq_rx == 1'b0, "R1 irq_rx", int'(irq_rx), 0);
    check(rts_n == 1'b0, "R1 rts_n", int'(rts_n), 0);
    check(status == 5'b00001, "R1 status", int'(status), 1);

    // R2 bit time with divisor 2; R3 8-bit loopback
    set_ctl(2, 1, 0, 1'b0);
    push(9'h0A5, 3'b000, "R3 len8");
    send_tx(9'h0A5);
    n = 0;
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0) begin n++; @(negedge clk); end
    check(n == 48, "R2 start bit length", n, 48);
    drain();

    // R3/R4 lengths and parity modes at divisor 0
    set_ctl(0, 0, 1, 1'b0);
    push(9'h055, 3'b000, "R3 len7 even");
    send_tx(9'h1D5);
    drain();
    set_ctl(0, 2, 2, 1'b0);
    push(9'h1C3, 3'b000, "R4 len9 odd");
    send_tx(9'h1C3);
    drain();
    set_ctl(0, 1, 2, 1'b0);
    push(9'h000, 3'b000, "R4 len8 odd zero");
    send_tx(9'h000);
    drain();

    // R4 raw even-parity frames: data 0x01, parity 1 correct, 0 wrong
    set_ctl(0, 1, 1, 1'b0);
    push(9'h001, 3'b000, "R4 good parity");
    raw({1'b1, 1'b1, 8'h01, 1'b0}, 11);
    drain();
    push(9'h001, 3'b001, "R4 bad parity");
    raw({1'b1, 1'b0, 8'h01, 1'b0}, 11);
    drain();

    // R5 low stop bit, no parity
    set_ctl(0, 1, 0, 1'b0);
    push(9'h03C, 3'b010, "R5 framing");
    raw({2'b11, 1'b0, 8'h3C, 1'b0}, 10);
    repeat (40) @(negedge clk);
    drain();

    // R8 short low glitch
    loop_sel = 1'b0;
    @(negedge clk); rxd_drv = 1'b0;
    repeat (4) @(negedge clk); rxd_drv = 1'b1;
    repeat (300) @(negedge clk);
    check(irq_rx == 1'b0, "R8 glitch ignored", int'(irq_rx), 0);
    loop_sel = 1'b1;

    // R6 overrun, R11 rts, R7 status clear
    mon_en = 1'b0;
    send_tx(9'h011);
    send_tx(9'h022);
    @(negedge clk);
    while (!irq_tx) @(negedge clk);
    repeat (30) @(negedge clk);
    check(status == 5'b10011, "R6 overrun status", int'(status), 5'h13);
    check(rx_rdata == 9'h011, "R6 held char kept", int'(rx_rdata), 9'h11);
    check(rts_n == 1'b1, "R11 rts_n while full", int'(rts_n), 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    check(status == 5'b00011, "R7 flags cleared", int'(status), 5'h03);
    rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    check(irq_rx == 1'b0 && rts_n == 1'b0, "R11 read empties", int'({irq_rx, rts_n}), 0);
    mon_en = 1'b1;

    // R9 address wake in 9-bit mode
    set_ctl(0, 2, 0, 1'b1);
    send_tx(9'h055);
    @(negedge clk);
    while (!irq_tx) @(negedge clk);
    repeat (40) @(negedge clk);
    check(irq_rx == 1'b0, "R9 data frame discarded", int'(irq_rx), 0);
    push(9'h1AA, 3'b000, "R9 address frame");
    send_tx(9'h1AA);
    drain();

    // R10 clear-to-send gating
    set_ctl(0, 1, 0, 1'b0);
    cts_n = 1'b1;
    send_tx(9'h05A);
    n = 0;
    repeat (200) begin @(negedge clk); if (txd !== 1'b1) n++; end
    check(n == 0, "R10 txd held while cts_n high", n, 0);
    check(irq_tx == 1'b0, "R10 irq_tx low while waiting", int'(irq_tx), 0);
    push(9'h05A, 3'b000, "R10 sent after cts");
    cts_n = 1'b0;
    drain();
    check(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);
    summary();
  end
endmodule